// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

The block is a hardware watchdog that software must keep alive. A 24-bit down-counter is loaded from a programmable reload value and steps down once per prescaled tick. The tick comes either from an internal reference strobe or from an external clock-enable input. When the counter is at zero and one more step arrives, the watchdog expires. It then sets a sticky expired flag and can fire a reset pulse, an interrupt pulse, or both. Each output has its own enable and its own programmable width. After an expiry the counter reloads and keeps running.

Software reaches the block through a small register port with four word addresses. Every writable register accepts a write only when the data word carries that register's own key. Each register has a different key. A stray or corrupted store is therefore discarded instead of changing the configuration or feeding the watchdog. Read data is registered and appears one clock after the address is presented.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset, all four addresses read 0, and `expired`, `rst_out` and `irq_out` are low.
- R2: A write to address 0 (mode) takes effect only if `wr_data[23:12]` equals 0xABC. The mode fields are: bit 0 is the global enable, bit 1 enables the reset output, bit 2 enables the interrupt output, bits [4:3] select the reset pulse width and bits [6:5] select the interrupt pulse width. Reading address 0 returns these seven bits with all other bits zero. A write with any other key leaves the register unchanged.
- R3: A write to address 1 (counter control) takes effect only if `wr_data[25:20]` equals 0x24. The control fields are: bits [1:0] select the prescaler, bits [13:2] hold the 12-bit reload field and bit 14 selects the external tick when set. Reading address 1 returns bits [14:0] with all other bits zero. A write with any other key leaves the register unchanged.
- R4: A write to address 2 whose whole data word equals 0x00001999 reloads the counter, clears the prescaler and clears the expired flag. Any other word written there has no effect. Address 2 reads 0.
- R5: The counter reloads to {reload field, 0xFFF}. It decrements once every 8, 64, 512 or 4096 selected ticks, for prescaler codes 0 to 3. When the enable is written, `expired` rises on the (reload+1)·divisor-th selected tick after the enabling write.
- R6: `expired` stays high until a valid restart or until the watchdog is disabled. Address 3 reads it in bit 0.
- R7: On expiry with the reset enable set, `rst_out` goes high in the same cycle as `expired`. It stays high for 4, 8, 16 or 32 cycles for width codes 0 to 3. With the reset enable clear, `rst_out` stays low.
- R8: On expiry with the interrupt enable set, `irq_out` goes high in the same cycle as `expired`. It stays high for 4, 8, 16 or 32 cycles for width codes 0 to 3. With the interrupt enable clear, `irq_out` stays low.
- R9: With bit 14 of the control register set, only `ext_tick` advances the prescaler and `int_tick` is ignored. With bit 14 clear, only `int_tick` advances it.
- R10: While the global enable is clear, the counter is held at its reload value and the watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Word address: 0 mode, 1 control, 2 restart, 3 status |
| wr_data | input | 32 | Write data, including the key |
| rd_data | output | 32 | Registered read data for `addr` |
| int_tick | input | 1 | Internal reference tick, one-cycle enable |
| ext_tick | input | 1 | External tick, one-cycle enable |
| expired | output | 1 | Sticky expiry flag |
| rst_out | output | 1 | Registered reset pulse |
| irq_out | output | 1 | Registered interrupt pulse |

## Verification
The hardest state to reach is the expiry itself. With the shortest prescaler and a zero reload field, the counter still needs 32768 selected ticks before it runs out. The bench therefore holds the chosen tick high every cycle and counts edges from the enabling write, so the exact expiry cycle and the pulse widths are compared against values worked out by hand. The external-source case holds the external tick low for a known stretch while the internal tick runs. That stretch must show up exactly as extra delay before expiry. Keep-alive and disable behaviour are shown by letting the counter run to within a few hundred ticks of expiry before the restart or disable write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    A_MODE    = 2'd0,
    A_CTRL    = 2'd1,
    A_RESTART = 2'd2,
    A_STATUS  = 2'd3
  } reg_addr_e;

  localparam int          MODE_KEY_LSB = 12;
  localparam int          MODE_KEY_W   = 12;
  localparam logic [11:0] MODE_KEY     = 12'hABC;
  localparam int          CTRL_KEY_LSB = 20;
  localparam int          CTRL_KEY_W   = 6;
  localparam logic [5:0]  CTRL_KEY     = 6'h24;
  localparam logic [31:0] RESTART_WORD = 32'h0000_1999;

  localparam int MODE_FIELD_W = 7;
  localparam int PSEL_W       = 2;
  localparam int WSEL_W       = 2;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                expired,
  output logic                en,
  output logic                rst_en,
  output logic                irq_en,
  output logic [WSEL_W-1:0]   rst_wsel,
  output logic [WSEL_W-1:0]   irq_wsel,
  output logic [PSEL_W-1:0]   psel,
  output logic [RELOAD_W-1:0] reload,
  output logic                ext_sel,
  output logic                restart_stb,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int CTRL_FIELD_W = PSEL_W + RELOAD_W + 1;

  logic mode_hit, ctrl_hit;
  logic [MODE_FIELD_W-1:0] mode_q;
  logic [CTRL_FIELD_W-1:0] ctrl_q;

  assign mode_hit = wr_en && (addr == A_MODE) &&
    (wr_data[MODE_KEY_LSB +: MODE_KEY_W] == MODE_KEY);
  assign ctrl_hit = wr_en && (addr == A_CTRL) &&
    (wr_data[CTRL_KEY_LSB +: CTRL_KEY_W] == CTRL_KEY);
  assign restart_stb = wr_en && (addr == A_RESTART) &&
    (wr_data == DATA_W'(RESTART_WORD));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (mode_hit) mode_q <= wr_data[MODE_FIELD_W-1:0];
      if (ctrl_hit) ctrl_q <= wr_data[CTRL_FIELD_W-1:0];
    end
  end

  assign en       = mode_q[0];
  assign rst_en   = mode_q[1];
  assign irq_en   = mode_q[2];
  assign rst_wsel = mode_q[3 +: WSEL_W];
  assign irq_wsel = mode_q[3 + WSEL_W +: WSEL_W];
  assign psel     = ctrl_q[PSEL_W-1:0];
  assign reload   = ctrl_q[PSEL_W +: RELOAD_W];
  assign ext_sel  = ctrl_q[CTRL_FIELD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (reg_addr_e'(addr))
        A_MODE:    rd_data <= DATA_W'(mode_q);
        A_CTRL:    rd_data <= DATA_W'(ctrl_q);
        A_RESTART: rd_data <= '0;
        A_STATUS:  rd_data <= DATA_W'(expired);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  input  logic              int_tick,
  input  logic              ext_tick,
  input  logic              ext_sel,
  input  logic [PSEL_W-1:0] psel,
  output logic              step
);
  localparam int PRE_W = BASE_SHIFT + STEP_SHIFT * ((1 << PSEL_W) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic [PRE_W:0]   span;
  logic             tick;

  always_comb begin
    span  = (PRE_W+1)'(1) << (BASE_SHIFT + STEP_SHIFT * int'(psel));
    limit = PRE_W'(span - 1'b1);
  end

  assign tick = ext_sel ? ext_tick : int_tick;
  assign step = run && !clear && tick && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= step ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 24,
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                restart,
  input  logic                step,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire_evt,
  output logic                expired
);
  localparam int LOW_W = CNT_W - RELOAD_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;

  assign reload_val = {reload, {LOW_W{1'b1}}};
  assign expire_evt = en && !restart && step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      expired <= 1'b0;
    end else if (!en || restart) begin
      cnt_q   <= reload_val;
      expired <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q   <= reload_val;
        expired <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int SEL_W  = 2,
  parameter int BASE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] wsel,
  output logic             pulse
);
  localparam int MAX_W = BASE_W << ((1 << SEL_W) - 1);
  localparam int LEN_W = $clog2(MAX_W);

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      pulse  <= 1'b1;
      left_q <= LEN_W'((BASE_W << wsel) - 1);
    end else if (pulse) begin
      if (left_q == '0) pulse <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 24,
  parameter int RELOAD_W   = 12,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 3,
  parameter int MIN_PULSE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              int_tick,
  input  logic              ext_tick,
  output logic              expired,
  output logic              rst_out,
  output logic              irq_out
);
  localparam int NCH = 2;

  logic en_w, rst_en_w, irq_en_w, ext_sel_w, restart_stb, step_w, expire_evt;
  logic [WSEL_W-1:0]   rst_wsel_w, irq_wsel_w;
  logic [PSEL_W-1:0]   psel_w;
  logic [RELOAD_W-1:0] reload_w;
  logic [NCH-1:0]      ch_fire, ch_out;
  logic [WSEL_W-1:0]   ch_wsel [NCH];

  wdt_regs #(.DATA_W(DATA_W), .RELOAD_W(RELOAD_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .expired(expired), .en(en_w), .rst_en(rst_en_w), .irq_en(irq_en_w),
    .rst_wsel(rst_wsel_w), .irq_wsel(irq_wsel_w), .psel(psel_w),
    .reload(reload_w), .ext_sel(ext_sel_w), .restart_stb(restart_stb),
    .rd_data(rd_data)
  );

  wdt_prescale #(.BASE_SHIFT(BASE_SHIFT), .STEP_SHIFT(STEP_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .run(en_w), .clear(restart_stb),
    .int_tick(int_tick), .ext_tick(ext_tick), .ext_sel(ext_sel_w),
    .psel(psel_w), .step(step_w)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_w), .restart(restart_stb), .step(step_w),
    .reload(reload_w), .expire_evt(expire_evt), .expired(expired)
  );

  assign ch_fire    = {expire_evt && irq_en_w, expire_evt && rst_en_w};
  assign ch_wsel[0] = rst_wsel_w;
  assign ch_wsel[1] = irq_wsel_w;

  for (genvar c = 0; c < NCH; c++) begin : g_pulse
    wdt_pulse #(.SEL_W(WSEL_W), .BASE_W(MIN_PULSE)) u_pulse (
      .clk(clk), .rst(rst), .fire(ch_fire[c]), .wsel(ch_wsel[c]),
      .pulse(ch_out[c])
    );
  end

  assign rst_out = ch_out[0];
  assign irq_out = ch_out[1];
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic rst_en,
  input logic irq_en,
  input logic restart_stb,
  input logic expired,
  input logic rst_out,
  input logic irq_out
);
  // R1
  reset_clears_outputs_chk: assert property (@(posedge clk)
    rst |=> (!expired && !rst_out && !irq_out));

  // R4
  restart_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    restart_stb |=> !expired);

  // R6
  expired_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && en && !restart_stb) |=> expired);

  // R7
  rst_rise_with_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out) |-> (expired && $past(rst_en)));

  // R8
  irq_rise_with_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> (expired && $past(irq_en)));

  // R10
  disabled_never_expired_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !expired);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
  .clk(clk), .rst(rst), .en(en_w), .rst_en(rst_en_w), .irq_en(irq_en_w),
  .restart_stb(restart_stb), .expired(expired), .rst_out(rst_out),
  .irq_out(irq_out)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        int_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        expired, rst_out, irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .int_tick(int_tick), .ext_tick(ext_tick),
    .expired(expired), .rst_out(rst_out), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  // Runs n edges after the last write; records first cycle of each event.
  task automatic watch(int n, int ext_delay, output int f_exp, output int f_rst,
                       output int rst_hi, output int f_irq, output int irq_hi);
    f_exp = -1; f_rst = -1; f_irq = -1; rst_hi = 0; irq_hi = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      if (expired && f_exp < 0) f_exp = i;
      if (rst_out) begin if (f_rst < 0) f_rst = i; rst_hi++; end
      if (irq_out) begin if (f_irq < 0) f_irq = i; irq_hi++; end
      if (ext_delay > 0 && i == ext_delay) ext_tick = 1'b1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 expired", expired, 0);
    check("R1 rst_out", rst_out, 0);
    check("R1 irq_out", irq_out, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 readback", d, 0);
    end
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(2'd0, 32'h00AB_D07F);
    rd(2'd0, d); check("R2 wrong mode key ignored", d, 0);
    wr(2'd0, 32'hFFAB_C07E);
    rd(2'd0, d); check("R2 mode write with key", d, 32'h7E);
    wr(2'd1, 32'h0250_7FFF);
    rd(2'd1, d); check("R3 wrong ctrl key ignored", d, 0);
    wr(2'd1, 32'h0240_7FFF);
    rd(2'd1, d); check("R3 ctrl write with key", d, 32'h7FFF);
    rd(2'd2, d); check("R4 restart reads zero", d, 0);
  endtask

  task automatic t_expire_rst();
    logic [31:0] d;
    int fe, fr, rh, fi, ih;
    int_tick = 1'b1; ext_tick = 1'b0;
    wr(2'd0, 32'h00AB_C000);
    wr(2'd1, 32'h0240_0000);
    rd(2'd1, d); check("R3 ctrl cleared", d, 0);
    wr(2'd0, 32'h00AB_C00B);
    watch(32800, 0, fe, fr, rh, fi, ih);
    check("R5 expiry cycle", fe, 32768);
    check("R7 rst_out start", fr, 32768);
    check("R7 rst_out width 8", rh, 8);
    check("R8 irq_out disabled", fi, -1);
    watch(100, 0, fe, fr, rh, fi, ih);
    check("R6 expired sticky", fe, 1);
    rd(2'd3, d); check("R6 status bit", d, 1);
    wr(2'd2, 32'h0001_1999);
    rd(2'd3, d); check("R4 wrong restart ignored", d, 1);
    wr(2'd2, 32'h0000_1999);
    check("R4 restart clears expired", expired, 0);
  endtask

  task automatic t_keepalive();
    int fe, fr, rh, fi, ih;
    wr(2'd2, 32'h0000_1999);
    watch(32000, 0, fe, fr, rh, fi, ih);
    check("R4 no expiry before restart", fe, -1);
    wr(2'd2, 32'h0000_1999);
    watch(32000, 0, fe, fr, rh, fi, ih);
    check("R4 restart kept alive", fe, -1);
    wr(2'd0, 32'h00AB_C00A);
    watch(1000, 0, fe, fr, rh, fi, ih);
    check("R10 disabled no expiry", fe, -1);
    check("R10 disabled no reset pulse", fr, -1);
  endtask

  task automatic t_external();
    int fe, fr, rh, fi, ih;
    int_tick = 1'b1; ext_tick = 1'b0;
    wr(2'd1, 32'h0240_4000);
    wr(2'd0, 32'h00AB_C005);
    watch(34800, 2000, fe, fr, rh, fi, ih);
    check("R9 external tick expiry cycle", fe, 34768);
    check("R8 irq_out start", fi, 34768);
    check("R8 irq_out width 4", ih, 4);
    check("R7 rst_out disabled", fr, -1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_keys();
    t_expire_rst();
    t_keepalive();
    t_external();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule